// File: doc/BRIEF.md
# Interrupt Source State Controller

This block keeps the per-source state for a parameterised bank of interrupt sources, numbered from a configurable base. Each source is either level-triggered or message-triggered, fixed by a static type input. For every source the block holds a target server, a current priority, a saved priority and four status flags: asserted (bit 0), sent (bit 1), rejected (bit 2) and masked-pending (bit 3). A priority of 0xFF means that the source is masked.

Source signals, a configuration port, reject and end-of-interrupt notifications from the presentation side, and a resend request all act on this state. The block emits delivery requests, one at a time, on a valid/ready output. Each request carries the target server, the source number (base plus index) and the priority. Presentation logic sits outside the block.

Top module: `irq_src_ctrl`

## Requirements
- R1: After reset no delivery is offered, and every source reads back server 0 and priority 0xFF. A source's level or message type comes from its static type input, so reset leaves it unchanged.
- R2: On a message source that is unmasked, a one-cycle high on its signal input raises `dlv_valid_o` two clock edges later. The request carries the source's server, number BASE+index and priority.
- R3: On a masked message source, a signal event produces no delivery and sets masked-pending. A later configuration write that leaves the source unmasked clears masked-pending and delivers the source.
- R4: A level source's asserted flag follows its signal input. The source is delivered when it is unmasked, asserted and not sent, and delivery sets sent. While sent stays set, a held input produces no further delivery.
- R5: A reject for a source sets its rejected flag and clears its sent flag. It does not cause a redelivery by itself.
- R6: On a resend request, every message source with rejected set clears that flag and is redelivered if it is unmasked. Every level source applies the R4 delivery rule again.
- R7: An end-of-interrupt clears sent for the named source. A level source is then checked again under the R4 rule, so a source that is still asserted is delivered again.
- R8: Configuration operation codes are 0 = set server and priority (the saved priority is set too), 1 = get, 2 = disable and 3 = enable. Disable writes priority 0xFF and saves the previous priority. Enable copies the saved priority into both priority fields.
- R9: One edge after each configuration request, the response is valid. Its status is 0x00 on success and 0xFD (-3) when the source number is outside [BASE, BASE+NUM_SRC). A set also returns 0xFD when the server is not below NUM_SRV or the 9-bit priority exceeds 0xFF. A failed request changes no state, and a get returns the server and priority.
- R10: When several sources are pending, the lowest index is offered first. An offered request holds steady until `dlv_ready_i` accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lvl_i | input | NUM_SRC | Per-source type, 1 = level, 0 = message |
| src_sig_i | input | NUM_SRC | Per-source signal (level value or one-cycle message event) |
| cfg_valid_i | input | 1 | Configuration request strobe |
| cfg_op_i | input | 2 | Operation: 0 set, 1 get, 2 disable, 3 enable |
| cfg_num_i | input | NUM_W | Source number for the request |
| cfg_srv_i | input | SRV_W | Server for a set |
| cfg_prio_i | input | 9 | Priority for a set (above 0xFF is refused) |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_status_o | output | 8 | 0x00 success, 0xFD failure |
| rsp_srv_o | output | SRV_W | Server returned by a get |
| rsp_prio_o | output | 8 | Priority returned by a get |
| rej_valid_i | input | 1 | Reject notification strobe |
| rej_num_i | input | NUM_W | Rejected source number |
| eoi_valid_i | input | 1 | End-of-interrupt strobe |
| eoi_num_i | input | NUM_W | Source number finishing service |
| resend_i | input | 1 | Resend request |
| dlv_valid_o | output | 1 | Delivery request offered |
| dlv_ready_i | input | 1 | Delivery request accepted |
| dlv_srv_o | output | SRV_W | Target server of the request |
| dlv_num_o | output | NUM_W | Source number of the request |
| dlv_prio_o | output | 8 | Priority of the request |

## Verification
A signal event, reject, end-of-interrupt, resend or configuration write updates source state at the first edge. Any delivery it causes appears at the output register one edge later, so the bench checks that the output is still idle after the first edge and carries the request after the second. A configuration response is due one edge after the request, and the bench reads it just after that edge. Cases that must produce no delivery are watched for several edges past the point where a delivery would have appeared.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;

  typedef enum logic [1:0] {
    OP_SET = 2'd0,
    OP_GET = 2'd1,
    OP_OFF = 2'd2,
    OP_ON  = 2'd3
  } cfg_op_e;

  localparam logic [7:0] PRIO_MASKED = 8'hFF;
  localparam logic [7:0] ST_OK       = 8'h00;
  localparam logic [7:0] ST_BAD      = 8'hFD;

  // flag bit positions
  localparam int FL_ASSERT = 0;
  localparam int FL_SENT   = 1;
  localparam int FL_REJ    = 2;
  localparam int FL_MPEND  = 3;

endpackage

// File: rtl/irq_num_decode.sv
module irq_num_decode #(
  parameter int NUM_SRC = 8,
  parameter int BASE    = 16,
  parameter int NUM_W   = 16,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_W-1:0] num_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [NUM_W:0] LO = (NUM_W+1)'(BASE);
  localparam logic [NUM_W:0] HI = (NUM_W+1)'(BASE + NUM_SRC);

  logic [NUM_W:0] wide;
  logic [NUM_W:0] diff;

  always_comb begin
    wide  = {1'b0, num_i};
    diff  = wide - LO;
    hit_o = (wide >= LO) && (wide < HI);
    idx_o = diff[IDX_W-1:0];
  end
endmodule

// File: rtl/irq_src_pick.sv
module irq_src_pick #(
  parameter int NUM_SRC = 8,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] req_i,
  output logic               any_o,
  output logic [NUM_SRC-1:0] grant_o,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    any_o   = |req_i;
    grant_o = req_i & (~req_i + NUM_SRC'(1));
    idx_o   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_src_slot.sv
module irq_src_slot
  import irq_src_pkg::*;
#(
  parameter int SRV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lvl_i,
  input  logic             sig_i,
  input  logic             wr_i,
  input  cfg_op_e          op_i,
  input  logic [SRV_W-1:0] srv_i,
  input  logic [7:0]       prio_i,
  input  logic             rej_i,
  input  logic             eoi_i,
  input  logic             resend_i,
  input  logic             issue_i,
  output logic [SRV_W-1:0] srv_o,
  output logic [7:0]       prio_o,
  output logic             want_o
);
  logic [SRV_W-1:0] srv_q, n_srv;
  logic [7:0]       prio_q, n_prio, sav_q, n_sav;
  logic [3:0]       flg_q, n_flg;
  logic             want_q, n_want, eval;

  always_comb begin
    n_srv  = srv_q;
    n_prio = prio_q;
    n_sav  = sav_q;
    n_flg  = flg_q;
    n_want = want_q & ~issue_i;
    eval   = 1'b0;

    if (wr_i) begin
      case (op_i)
        OP_SET: begin n_srv = srv_i; n_prio = prio_i; n_sav = prio_i; end
        OP_OFF: begin n_prio = PRIO_MASKED; n_sav = prio_q; end
        OP_ON:  begin n_prio = sav_q; end
        default: ;
      endcase
      if (lvl_i) eval = 1'b1;
      else if (n_flg[FL_MPEND] && (n_prio != PRIO_MASKED)) begin
        n_flg[FL_MPEND] = 1'b0;
        n_want          = 1'b1;
      end
    end

    if (lvl_i) begin
      if (sig_i != flg_q[FL_ASSERT]) eval = 1'b1;
      n_flg[FL_ASSERT] = sig_i;
    end else if (sig_i) begin
      if (n_prio == PRIO_MASKED) n_flg[FL_MPEND] = 1'b1;
      else                       n_want = 1'b1;
    end

    if (rej_i) begin
      n_flg[FL_REJ]  = 1'b1;
      n_flg[FL_SENT] = 1'b0;
    end

    if (eoi_i) begin
      n_flg[FL_SENT] = 1'b0;
      if (lvl_i) eval = 1'b1;
    end

    if (resend_i) begin
      if (lvl_i) eval = 1'b1;
      else if (n_flg[FL_REJ]) begin
        n_flg[FL_REJ] = 1'b0;
        if (n_prio != PRIO_MASKED) n_want = 1'b1;
      end
    end

    if (eval && (n_prio != PRIO_MASKED) && n_flg[FL_ASSERT] && !n_flg[FL_SENT]) begin
      n_flg[FL_SENT] = 1'b1;
      n_want         = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      srv_q  <= '0;
      prio_q <= PRIO_MASKED;
      sav_q  <= PRIO_MASKED;
      flg_q  <= '0;
      want_q <= 1'b0;
    end else begin
      srv_q  <= n_srv;
      prio_q <= n_prio;
      sav_q  <= n_sav;
      flg_q  <= n_flg;
      want_q <= n_want;
    end
  end

  assign srv_o  = srv_q;
  assign prio_o = prio_q;
  assign want_o = want_q;

  // R5: a reject leaves the rejected flag set unless a resend consumes it
  a_r5_reject_marks: assert property (@(posedge clk) disable iff (rst)
    rej_i && !resend_i |=> flg_q[FL_REJ]);

  // R5: a reject alone clears sent
  a_r5_reject_unsent: assert property (@(posedge clk) disable iff (rst)
    rej_i && !resend_i && !eoi_i && !wr_i && (sig_i == flg_q[FL_ASSERT])
    |=> !flg_q[FL_SENT]);

  // R3: masked-pending only rises while the source is masked
  a_r3_mpend_masked: assert property (@(posedge clk) disable iff (rst)
    $rose(flg_q[FL_MPEND]) |-> (prio_q == PRIO_MASKED));

  // R4: level sources never hold masked-pending
  a_r4_level_no_mpend: assert property (@(posedge clk) disable iff (rst)
    lvl_i |-> !flg_q[FL_MPEND]);

  // R8: disable leaves the source masked
  a_r8_off_masks: assert property (@(posedge clk) disable iff (rst)
    wr_i && (op_i == OP_OFF) |=> (prio_q == PRIO_MASKED));
endmodule

// File: rtl/irq_src_ctrl.sv
module irq_src_ctrl
  import irq_src_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int BASE    = 16,
  parameter int NUM_W   = 16,
  parameter int NUM_SRV = 4,
  parameter int SRV_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_lvl_i,
  input  logic [NUM_SRC-1:0] src_sig_i,
  input  logic               cfg_valid_i,
  input  logic [1:0]         cfg_op_i,
  input  logic [NUM_W-1:0]   cfg_num_i,
  input  logic [SRV_W-1:0]   cfg_srv_i,
  input  logic [8:0]         cfg_prio_i,
  output logic               rsp_valid_o,
  output logic [7:0]         rsp_status_o,
  output logic [SRV_W-1:0]   rsp_srv_o,
  output logic [7:0]         rsp_prio_o,
  input  logic               rej_valid_i,
  input  logic [NUM_W-1:0]   rej_num_i,
  input  logic               eoi_valid_i,
  input  logic [NUM_W-1:0]   eoi_num_i,
  input  logic               resend_i,
  output logic               dlv_valid_o,
  input  logic               dlv_ready_i,
  output logic [SRV_W-1:0]   dlv_srv_o,
  output logic [NUM_W-1:0]   dlv_num_o,
  output logic [7:0]         dlv_prio_o
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam logic [SRV_W-1:0] SRV_LIM = SRV_W'(NUM_SRV);
  localparam logic [NUM_W-1:0] NUM_LO  = NUM_W'(BASE);
  localparam logic [NUM_W-1:0] NUM_HI  = NUM_W'(BASE + NUM_SRC);

  cfg_op_e op;
  assign op = cfg_op_e'(cfg_op_i);

  logic             cfg_hit, rej_hit, eoi_hit, cfg_ok;
  logic [IDX_W-1:0] cfg_idx, rej_idx, eoi_idx, gidx;

  irq_num_decode #(.NUM_SRC(NUM_SRC), .BASE(BASE), .NUM_W(NUM_W)) u_dec_cfg (
    .num_i(cfg_num_i), .hit_o(cfg_hit), .idx_o(cfg_idx));
  irq_num_decode #(.NUM_SRC(NUM_SRC), .BASE(BASE), .NUM_W(NUM_W)) u_dec_rej (
    .num_i(rej_num_i), .hit_o(rej_hit), .idx_o(rej_idx));
  irq_num_decode #(.NUM_SRC(NUM_SRC), .BASE(BASE), .NUM_W(NUM_W)) u_dec_eoi (
    .num_i(eoi_num_i), .hit_o(eoi_hit), .idx_o(eoi_idx));

  assign cfg_ok = cfg_hit &&
                  ((op != OP_SET) || ((cfg_srv_i < SRV_LIM) && !cfg_prio_i[8]));

  logic [SRV_W-1:0]   srv_a  [NUM_SRC];
  logic [7:0]         prio_a [NUM_SRC];
  logic [NUM_SRC-1:0] want, elig, grant, issue;
  logic               any, load;

  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_slot
      logic wr, rj, eo;
      assign wr = cfg_valid_i && cfg_ok && (op != OP_GET) && (cfg_idx == IDX_W'(g));
      assign rj = rej_valid_i && rej_hit && (rej_idx == IDX_W'(g));
      assign eo = eoi_valid_i && eoi_hit && (eoi_idx == IDX_W'(g));

      irq_src_slot #(.SRV_W(SRV_W)) u_slot (
        .clk(clk), .rst(rst),
        .lvl_i(src_lvl_i[g]), .sig_i(src_sig_i[g]),
        .wr_i(wr), .op_i(op), .srv_i(cfg_srv_i), .prio_i(cfg_prio_i[7:0]),
        .rej_i(rj), .eoi_i(eo), .resend_i(resend_i), .issue_i(issue[g]),
        .srv_o(srv_a[g]), .prio_o(prio_a[g]), .want_o(want[g]));

      assign elig[g] = want[g] && (prio_a[g] != PRIO_MASKED);
    end
  endgenerate

  irq_src_pick #(.NUM_SRC(NUM_SRC)) u_pick (
    .req_i(elig), .any_o(any), .grant_o(grant), .idx_o(gidx));

  assign load  = !dlv_valid_o || dlv_ready_i;
  assign issue = load ? grant : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      dlv_valid_o <= 1'b0;
      dlv_srv_o   <= '0;
      dlv_num_o   <= '0;
      dlv_prio_o  <= '0;
    end else if (load) begin
      dlv_valid_o <= any;
      dlv_srv_o   <= srv_a[gidx];
      dlv_num_o   <= NUM_LO + NUM_W'(gidx);
      dlv_prio_o  <= prio_a[gidx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_o  <= 1'b0;
      rsp_status_o <= ST_OK;
      rsp_srv_o    <= '0;
      rsp_prio_o   <= '0;
    end else begin
      rsp_valid_o  <= cfg_valid_i;
      rsp_status_o <= cfg_ok ? ST_OK : ST_BAD;
      if (cfg_valid_i && cfg_ok && (op == OP_GET)) begin
        rsp_srv_o  <= srv_a[cfg_idx];
        rsp_prio_o <= prio_a[cfg_idx];
      end else begin
        rsp_srv_o  <= '0;
        rsp_prio_o <= '0;
      end
    end
  end

  // R10: an offered request holds until accepted
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    dlv_valid_o && !dlv_ready_i |=> dlv_valid_o && $stable(dlv_num_o)
      && $stable(dlv_srv_o) && $stable(dlv_prio_o));

  // R2: offered requests are never masked and name a source in range
  a_r2_unmasked: assert property (@(posedge clk) disable iff (rst)
    dlv_valid_o |-> (dlv_prio_o != PRIO_MASKED));
  a_r2_num_range: assert property (@(posedge clk) disable iff (rst)
    dlv_valid_o |-> (dlv_num_o >= NUM_LO) && (dlv_num_o < NUM_HI));

  // R9: a bad source number fails on the next edge
  a_r9_bad_num: assert property (@(posedge clk) disable iff (rst)
    cfg_valid_i && !cfg_hit |=> rsp_valid_o && (rsp_status_o == ST_BAD));

  // R9: one response per request
  a_r9_rsp_follows: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_o |-> $past(cfg_valid_i));
endmodule

// File: tb/tb_irq_src_ctrl.sv
module tb_irq_src_ctrl;
  localparam int NUM_SRC = 8;
  localparam int BASE    = 16;
  localparam int NUM_W   = 16;
  localparam int NUM_SRV = 4;
  localparam int SRV_W   = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [NUM_SRC-1:0] src_lvl = 8'b1111_0000;
  logic [NUM_SRC-1:0] sig = '0;
  logic cfg_valid = 0; logic [1:0] cfg_op = 0; logic [NUM_W-1:0] cfg_num = 0;
  logic [SRV_W-1:0] cfg_srv = 0; logic [8:0] cfg_prio = 0;
  logic rsp_valid; logic [7:0] rsp_status; logic [SRV_W-1:0] rsp_srv; logic [7:0] rsp_prio;
  logic rej_valid = 0; logic [NUM_W-1:0] rej_num = 0;
  logic eoi_valid = 0; logic [NUM_W-1:0] eoi_num = 0;
  logic resend = 0;
  logic dlv_valid; logic dlv_ready = 0;
  logic [SRV_W-1:0] dlv_srv; logic [NUM_W-1:0] dlv_num; logic [7:0] dlv_prio;

  irq_src_ctrl #(.NUM_SRC(NUM_SRC), .BASE(BASE), .NUM_W(NUM_W),
                 .NUM_SRV(NUM_SRV), .SRV_W(SRV_W)) dut (
    .clk(clk), .rst(rst), .src_lvl_i(src_lvl), .src_sig_i(sig),
    .cfg_valid_i(cfg_valid), .cfg_op_i(cfg_op), .cfg_num_i(cfg_num),
    .cfg_srv_i(cfg_srv), .cfg_prio_i(cfg_prio),
    .rsp_valid_o(rsp_valid), .rsp_status_o(rsp_status), .rsp_srv_o(rsp_srv),
    .rsp_prio_o(rsp_prio),
    .rej_valid_i(rej_valid), .rej_num_i(rej_num),
    .eoi_valid_i(eoi_valid), .eoi_num_i(eoi_num), .resend_i(resend),
    .dlv_valid_o(dlv_valid), .dlv_ready_i(dlv_ready), .dlv_srv_o(dlv_srv),
    .dlv_num_o(dlv_num), .dlv_prio_o(dlv_prio));

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] num;
    logic [7:0]  srv;
    logic [8:0]  prio;
    logic [7:0]  st;
    logic [7:0]  gsrv;
    logic [7:0]  gprio;
  } vec_t;

  // op: 0 set, 1 get, 2 disable, 3 enable
  localparam vec_t VEC [12] = '{
    '{2'd0, 16'd16, 8'd1, 9'h005, 8'h00, 8'd0, 8'h00},
    '{2'd1, 16'd16, 8'd0, 9'h000, 8'h00, 8'd1, 8'h05},
    '{2'd0, 16'd15, 8'd0, 9'h001, 8'hFD, 8'd0, 8'h00},
    '{2'd0, 16'd24, 8'd0, 9'h001, 8'hFD, 8'd0, 8'h00},
    '{2'd0, 16'd17, 8'd4, 9'h001, 8'hFD, 8'd0, 8'h00},
    '{2'd0, 16'd17, 8'd2, 9'h100, 8'hFD, 8'd0, 8'h00},
    '{2'd1, 16'd17, 8'd0, 9'h000, 8'h00, 8'd0, 8'hFF},
    '{2'd2, 16'd16, 8'd0, 9'h000, 8'h00, 8'd0, 8'h00},
    '{2'd1, 16'd16, 8'd0, 9'h000, 8'h00, 8'd1, 8'hFF},
    '{2'd3, 16'd16, 8'd0, 9'h000, 8'h00, 8'd0, 8'h00},
    '{2'd1, 16'd16, 8'd0, 9'h000, 8'h00, 8'd1, 8'h05},
    '{2'd1, 16'd24, 8'd0, 9'h000, 8'hFD, 8'd0, 8'h00}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic cfg_do(input logic [1:0] op, input int num, input int srv, input int prio);
    cfg_valid = 1; cfg_op = op; cfg_num = NUM_W'(num);
    cfg_srv = SRV_W'(srv); cfg_prio = 9'(prio);
    tick();
    cfg_valid = 0;
  endtask

  task automatic expect_dlv(input string tag, input int num, input int srv, input int prio);
    chk(dlv_valid === 1'b1, {tag, " valid"}, 32'(dlv_valid), 1);
    chk(dlv_num === NUM_W'(num), {tag, " num"}, 32'(dlv_num), 32'(num));
    chk(dlv_srv === SRV_W'(srv), {tag, " srv"}, 32'(dlv_srv), 32'(srv));
    chk(dlv_prio === 8'(prio), {tag, " prio"}, 32'(dlv_prio), 32'(prio));
  endtask

  task automatic expect_idle(input string tag);
    chk(dlv_valid === 1'b0, {tag, " idle"}, 32'(dlv_valid), 0);
  endtask

  task automatic accept();
    dlv_ready = 1; tick(); dlv_ready = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1;
    repeat (3) tick();
    rst = 0;
    tick();
    expect_idle("R1 reset");
    cfg_do(2'd1, 16, 0, 0);
    chk(rsp_valid === 1'b1 && rsp_status === 8'h00, "R1 get status", 32'(rsp_status), 0);
    chk(rsp_srv === 8'd0 && rsp_prio === 8'hFF, "R1 get fields", 32'(rsp_prio), 32'hFF);

    // R8 R9 configuration table
    for (int i = 0; i < 12; i++) begin
      cfg_do(VEC[i].op, int'(VEC[i].num), int'(VEC[i].srv), int'(VEC[i].prio));
      chk(rsp_valid === 1'b1, "R9 rsp valid", 32'(rsp_valid), 1);
      chk(rsp_status === VEC[i].st, "R9 status", 32'(rsp_status), 32'(VEC[i].st));
      chk(rsp_srv === VEC[i].gsrv && rsp_prio === VEC[i].gprio, "R8 get fields",
          {16'(rsp_srv), 16'(rsp_prio)}, {16'(VEC[i].gsrv), 16'(VEC[i].gprio)});
    end

    // R2 message delivery, two edges after the event
    sig[0] = 1; tick(); sig[0] = 0;
    expect_idle("R2 first edge");
    tick();
    expect_dlv("R2", 16, 1, 5);
    accept();
    expect_idle("R2 accepted");

    // R3 masked message, then set unmasks it
    sig[1] = 1; tick(); sig[1] = 0; tick(); tick();
    expect_idle("R3 masked");
    cfg_do(2'd0, 17, 2, 3);
    chk(rsp_status === 8'h00, "R3 set status", 32'(rsp_status), 0);
    tick();
    expect_dlv("R3 pending", 17, 2, 3);
    accept();

    // R5 reject, R6 resend for a message source
    rej_valid = 1; rej_num = 17; tick(); rej_valid = 0; tick(); tick();
    expect_idle("R5 msg no redelivery");
    resend = 1; tick(); resend = 0; tick();
    expect_dlv("R6 msg resend", 17, 2, 3);
    accept();
    resend = 1; tick(); resend = 0; tick();
    expect_idle("R6 flag consumed");

    // R4 level source
    cfg_do(2'd0, 20, 3, 7);
    expect_idle("R4 not asserted");
    sig[4] = 1; tick(); tick();
    expect_dlv("R4 level", 20, 3, 7);
    accept(); tick(); tick();
    expect_idle("R4 sent blocks");

    // R7 end-of-interrupt on asserted level
    eoi_valid = 1; eoi_num = 20; tick(); eoi_valid = 0; tick();
    expect_dlv("R7 eoi redeliver", 20, 3, 7);
    accept();

    // R5 reject level, R6 resend
    rej_valid = 1; rej_num = 20; tick(); rej_valid = 0; tick(); tick();
    expect_idle("R5 level no redelivery");
    resend = 1; tick(); resend = 0; tick();
    expect_dlv("R6 level resend", 20, 3, 7);
    accept();
    sig[4] = 0;
    eoi_valid = 1; eoi_num = 20; tick(); eoi_valid = 0; tick(); tick();
    expect_idle("R7 deasserted");

    // R10 ordering and hold
    cfg_do(2'd0, 18, 0, 2);
    cfg_do(2'd0, 19, 1, 4);
    sig[0] = 1; sig[2] = 1; sig[3] = 1; tick(); sig = '0; tick();
    expect_dlv("R10 first", 16, 1, 5);
    tick(); tick(); tick();
    expect_dlv("R10 held", 16, 1, 5);
    accept();
    expect_dlv("R10 second", 18, 0, 2);
    accept();
    expect_dlv("R10 third", 19, 1, 4);
    accept();
    expect_idle("R10 drained");

    // R8 disable then enable releases masked-pending
    cfg_do(2'd2, 16, 0, 0);
    sig[0] = 1; tick(); sig[0] = 0; tick(); tick();
    expect_idle("R8 disabled");
    cfg_do(2'd3, 16, 0, 0);
    tick();
    expect_dlv("R8 enable", 16, 1, 5);
    accept();

    // R1 reset again
    rst = 1; tick(); tick(); rst = 0; tick();
    expect_idle("R1 second reset");
    cfg_do(2'd1, 20, 0, 0);
    chk(rsp_srv === 8'd0 && rsp_prio === 8'hFF, "R1 state cleared", 32'(rsp_prio), 32'hFF);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule